// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent logical-to-physical page mappings and answers translation requests against all of them at once. A request carries a 32-bit logical address, a 3-bit address-space code and a read/write flag. One cycle later the block reports a hit or a miss. On a hit it also reports the physical address, the page attributes, any protection fault and whether the page's modified bit must be written back. A table-walk engine or software loads new mappings through a fill port. The fill takes one cycle and picks its slot on its own.

The page size can be changed at run time. Eight sizes are offered, each a power of two from 256 bytes to 32 KB. Up to 15 of the most significant logical bits can be left out of translation. Translation can be switched off by a software enable or by an external override pin. The address then passes through unchanged.

Top module: `xlat_cache`

## Requirements
- R1: A lookup presented with `lk_valid` high at a rising edge has its result on the `rsp_*` outputs after that edge, with `rsp_valid` high for exactly that one cycle. A fill in the same cycle as a lookup is not visible to that lookup.
- R2: All 22 slots can hold separate mappings. On a hit, the physical address is the stored frame bits above the page offset, joined with the offset bits of the logical address.
- R3: `page_sel` value p selects a page of 256·2^p bytes, so the offset is the low 8+p bits. Offset bits are not compared and pass straight from the logical address to the physical address.
- R4: The 3-bit code `lk_fc` is part of the tag. The same logical address under a different code does not hit. Bit 2 of the code set means supervisor; bit 2 clear means user.
- R5: A write that hits a write-protected entry reports `rsp_fault`=1, with the physical address 0 and no modified update.
- R6: A hit from a user code on a supervisor-only entry reports `rsp_fault`=1. A hit from a supervisor code on the same kind of entry does not fault.
- R7: `rsp_ci` follows the cache-inhibit attribute of the entry that hit, and is 0 on misses and in bypass.
- R8: `ign_bits` value k (0 to 15) removes logical bits 31 down to 32−k from the tag compare. The same bits are stored as zero in the tag at fill time.
- R9: When `xlat_off` is 1 or `xlat_enable` is 0, a lookup reports a hit with the physical address equal to the logical address, and no fault, inhibit or modified update.
- R10: The first fault-free write hit on an entry whose modified bit is clear reports `rsp_mod_update`=1, with `rsp_mod` showing the old value 0. After that the bit is set. A read, a faulting write, or a write to an entry already marked modified gives no update.
- R11: A miss reports `rsp_miss`=1, `rsp_hit`=0, physical address 0 and no fault.
- R12: A fill with no matching tag writes the lowest-indexed invalid slot. If every slot is valid, it writes the lowest-indexed slot whose reference bit is clear. A fill or a lookup hit sets the slot's reference bit. When all reference bits would be set, only the bits touched in that cycle are kept.
- R13: `flush` invalidates every entry and clears every reference bit in one cycle. Flush takes priority over a fill in the same cycle.
- R14: A fill whose code and masked address match a valid entry overwrites that entry in place, so a later lookup returns only the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_enable | input | 1 | Software translation enable |
| xlat_off | input | 1 | External translation override (1 = bypass) |
| page_sel | input | 3 | Page size select, 256·2^value bytes |
| ign_bits | input | 4 | Count of upper logical bits to ignore |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup logical address |
| lk_fc | input | 3 | Lookup address-space code |
| lk_write | input | 1 | Lookup is a write |
| fill_valid | input | 1 | Load a mapping |
| fill_laddr | input | 32 | Logical address of mapping |
| fill_fc | input | 3 | Address-space code of mapping |
| fill_paddr | input | 32 | Physical frame address of mapping |
| fill_wp | input | 1 | Write-protect attribute |
| fill_so | input | 1 | Supervisor-only attribute |
| fill_ci | input | 1 | Cache-inhibit attribute |
| fill_mod | input | 1 | Initial modified bit |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Translation found or bypassed |
| rsp_miss | output | 1 | No mapping present |
| rsp_paddr | output | 32 | Physical address (0 on miss or fault) |
| rsp_fault | output | 1 | Protection fault |
| rsp_wp | output | 1 | Write-protect attribute of hit entry |
| rsp_so | output | 1 | Supervisor-only attribute of hit entry |
| rsp_ci | output | 1 | Cache inhibit for this access |
| rsp_mod | output | 1 | Modified bit of hit entry before this access |
| rsp_mod_update | output | 1 | Modified bit must be written back |

## Verification
The bench builds the block with its default 22 slots. That depth lets it fill every slot, read each one back, and then force two evictions whose victims depend on the exact reference-bit history. The page-size and ignore-count inputs are moved at run time through the extremes of their ranges (256 B and 32 KB pages, 0, 4 and 15 ignored bits). This shows the offset passing through and the stored-tag masking without rebuilding the block.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W    = 32;
    localparam int FC_W    = 3;
    localparam int PSEL_W  = 3;
    localparam int IGN_W   = 4;
    localparam int MIN_OFF = 8;

    typedef struct packed {
        logic            valid;
        logic [FC_W-1:0] fc;
        logic [VA_W-1:0] tag;
        logic [VA_W-1:0] frame;
        logic            wp;
        logic            so;
        logic            ci;
        logic            mod;
    } xent_t;

    // bits that form the in-page offset for a given size select
    function automatic logic [VA_W-1:0] offset_mask(input logic [PSEL_W-1:0] psel);
        logic [VA_W-1:0] m;
        for (int i = 0; i < VA_W; i++) m[i] = (i < MIN_OFF + int'(psel));
        return m;
    endfunction

    // bits that take part in the tag compare
    function automatic logic [VA_W-1:0] tag_mask(input logic [PSEL_W-1:0] psel,
                                                 input logic [IGN_W-1:0]  ign);
        logic [VA_W-1:0] m;
        for (int i = 0; i < VA_W; i++)
            m[i] = (i >= MIN_OFF + int'(psel)) && (i < VA_W - int'(ign));
        return m;
    endfunction

    function automatic logic is_user(input logic [FC_W-1:0] fc);
        return !fc[FC_W-1];
    endfunction

endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
    import xlat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            wr_en,
    input  logic            set_mod,
    input  xent_t           wr_ent,
    input  logic [VA_W-1:0] cmp_mask,
    input  logic [VA_W-1:0] lk_addr,
    input  logic [FC_W-1:0] lk_fc,
    input  logic [VA_W-1:0] fl_addr,
    input  logic [FC_W-1:0] fl_fc,
    output logic            lk_match,
    output logic            fl_match,
    output xent_t           ent
);

    logic [VA_W-1:0] tag_cmp;

    assign tag_cmp  = ent.tag & cmp_mask;
    assign lk_match = ent.valid && (ent.fc == lk_fc) && ((lk_addr & cmp_mask) == tag_cmp);
    assign fl_match = ent.valid && (ent.fc == fl_fc) && ((fl_addr & cmp_mask) == tag_cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (flush) begin
            ent.valid <= 1'b0;
        end else if (wr_en) begin
            ent <= wr_ent;
        end else if (set_mod) begin
            ent.mod <= 1'b1;
        end
    end

endmodule

// File: rtl/xlat_repl.sv
module xlat_repl #(
    parameter int N = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic [N-1:0] valid_vec,
    input  logic [N-1:0] touch_vec,
    output logic [N-1:0] victim_oh
);

    logic [N-1:0] use_q;
    logic [N-1:0] use_d;
    logic         found;

    always_comb begin
        victim_oh = '0;
        found     = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!found && !valid_vec[i]) begin
                victim_oh[i] = 1'b1;
                found        = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (!found && !use_q[i]) begin
                victim_oh[i] = 1'b1;
                found        = 1'b1;
            end
        end
        if (!found) victim_oh[0] = 1'b1;
    end

    always_comb begin
        use_d = use_q | touch_vec;
        if (&use_d) use_d = touch_vec;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) use_q <= '0;
        else              use_q <= use_d;
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N_ENT = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xlat_enable,
    input  logic              xlat_off,
    input  logic [PSEL_W-1:0] page_sel,
    input  logic [IGN_W-1:0]  ign_bits,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_addr,
    input  logic [FC_W-1:0]   lk_fc,
    input  logic              lk_write,
    input  logic              fill_valid,
    input  logic [VA_W-1:0]   fill_laddr,
    input  logic [FC_W-1:0]   fill_fc,
    input  logic [VA_W-1:0]   fill_paddr,
    input  logic              fill_wp,
    input  logic              fill_so,
    input  logic              fill_ci,
    input  logic              fill_mod,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_wp,
    output logic              rsp_so,
    output logic              rsp_ci,
    output logic              rsp_mod,
    output logic              rsp_mod_update
);

    logic              bypass;
    logic [VA_W-1:0]   cmp_mask;
    logic [VA_W-1:0]   off_mask;
    xent_t             new_ent;
    xent_t             ents [N_ENT];
    xent_t             sel;
    logic [N_ENT-1:0]  lk_match_vec;
    logic [N_ENT-1:0]  fl_match_vec;
    logic [N_ENT-1:0]  hit_vec;
    logic [N_ENT-1:0]  valid_vec;
    logic [N_ENT-1:0]  victim_oh;
    logic [N_ENT-1:0]  target_oh;
    logic [N_ENT-1:0]  wr_vec;
    logic [N_ENT-1:0]  setmod_vec;
    logic              hit;
    logic              fault;
    logic              mod_need;

    assign bypass   = xlat_off || !xlat_enable;
    assign cmp_mask = tag_mask(page_sel, ign_bits);
    assign off_mask = offset_mask(page_sel);

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.fc    = fill_fc;
        new_ent.tag   = fill_laddr & cmp_mask;
        new_ent.frame = fill_paddr & ~off_mask;
        new_ent.wp    = fill_wp;
        new_ent.so    = fill_so;
        new_ent.ci    = fill_ci;
        new_ent.mod   = fill_mod;
    end

    // a fill that hits an existing tag reuses that slot, otherwise the victim
    assign target_oh  = (|fl_match_vec) ? fl_match_vec : victim_oh;
    assign wr_vec     = target_oh & {N_ENT{fill_valid}};
    assign hit_vec    = lk_match_vec & {N_ENT{lk_valid && !bypass}};
    assign hit        = |hit_vec;
    assign setmod_vec = hit_vec & {N_ENT{mod_need}};

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_slot
            xlat_entry u_ent (
                .clk      (clk),
                .rst      (rst),
                .flush    (flush),
                .wr_en    (wr_vec[g]),
                .set_mod  (setmod_vec[g]),
                .wr_ent   (new_ent),
                .cmp_mask (cmp_mask),
                .lk_addr  (lk_addr),
                .lk_fc    (lk_fc),
                .fl_addr  (fill_laddr),
                .fl_fc    (fill_fc),
                .lk_match (lk_match_vec[g]),
                .fl_match (fl_match_vec[g]),
                .ent      (ents[g])
            );
            assign valid_vec[g] = ents[g].valid;
        end
    endgenerate

    xlat_repl #(.N(N_ENT)) u_repl (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .valid_vec (valid_vec),
        .touch_vec (hit_vec | wr_vec),
        .victim_oh (victim_oh)
    );

    // at most one slot matches, so an OR across hitting slots selects it
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_ENT; i++)
            if (hit_vec[i]) sel = xent_t'(sel | ents[i]);
    end

    assign fault    = hit && ((lk_write && sel.wp) || (is_user(lk_fc) && sel.so));
    assign mod_need = hit && !fault && lk_write && !sel.mod;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_miss       <= 1'b0;
            rsp_paddr      <= '0;
            rsp_fault      <= 1'b0;
            rsp_wp         <= 1'b0;
            rsp_so         <= 1'b0;
            rsp_ci         <= 1'b0;
            rsp_mod        <= 1'b0;
            rsp_mod_update <= 1'b0;
        end else begin
            rsp_valid      <= lk_valid;
            rsp_hit        <= 1'b0;
            rsp_miss       <= 1'b0;
            rsp_paddr      <= '0;
            rsp_fault      <= 1'b0;
            rsp_wp         <= 1'b0;
            rsp_so         <= 1'b0;
            rsp_ci         <= 1'b0;
            rsp_mod        <= 1'b0;
            rsp_mod_update <= 1'b0;
            if (lk_valid) begin
                if (bypass) begin
                    rsp_hit   <= 1'b1;
                    rsp_paddr <= lk_addr;
                end else if (hit) begin
                    rsp_hit        <= 1'b1;
                    rsp_fault      <= fault;
                    rsp_paddr      <= fault ? '0 :
                                      ((sel.frame & ~off_mask) | (lk_addr & off_mask));
                    rsp_wp         <= sel.wp;
                    rsp_so         <= sel.so;
                    rsp_ci         <= sel.ci;
                    rsp_mod        <= sel.mod;
                    rsp_mod_update <= mod_need;
                end else begin
                    rsp_miss <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              xlat_enable,
    input logic              xlat_off,
    input logic [PSEL_W-1:0] page_sel,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_addr,
    input logic [FC_W-1:0]   lk_fc,
    input logic              lk_write,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [VA_W-1:0]   rsp_paddr,
    input logic              rsp_fault,
    input logic              rsp_mod_update
);

    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    assert_hit_xor_miss_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_paddr == '0) && !rsp_fault && !rsp_mod_update);

    assert_bypass_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && (xlat_off || !xlat_enable)) |=>
            rsp_hit && !rsp_fault && !rsp_mod_update && (rsp_paddr == $past(lk_addr)));

    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!rsp_hit || rsp_fault ||
            (((rsp_paddr ^ $past(lk_addr)) & offset_mask($past(page_sel))) == '0)));

    assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0) && !rsp_mod_update && rsp_hit);

    assert_modupd_on_write_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_mod_update |-> $past(lk_write) && rsp_hit);

    assert_super_read_ok_R6: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_write && !is_user(lk_fc)) |=> !rsp_fault);

endmodule

bind xlat_cache xlat_cache_chk u_chk (.*);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xlat_enable = 1'b1;
    logic        xlat_off = 1'b0;
    logic [2:0]  page_sel = 3'd0;
    logic [3:0]  ign_bits = 4'd0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [2:0]  lk_fc = '0;
    logic        lk_write = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_laddr = '0;
    logic [2:0]  fill_fc = '0;
    logic [31:0] fill_paddr = '0;
    logic        fill_wp = 1'b0;
    logic        fill_so = 1'b0;
    logic        fill_ci = 1'b0;
    logic        fill_mod = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic        rsp_wp, rsp_so, rsp_ci, rsp_mod, rsp_mod_update;
    logic [31:0] rsp_paddr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        g_hit, g_miss, g_fault, g_ci, g_mod, g_mu, g_valid;
    logic [31:0] g_pa;

    always #2 clk = ~clk;

    xlat_cache dut (
        .clk(clk), .rst(rst), .xlat_enable(xlat_enable), .xlat_off(xlat_off),
        .page_sel(page_sel), .ign_bits(ign_bits), .flush(flush),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_fc(lk_fc), .lk_write(lk_write),
        .fill_valid(fill_valid), .fill_laddr(fill_laddr), .fill_fc(fill_fc),
        .fill_paddr(fill_paddr), .fill_wp(fill_wp), .fill_so(fill_so),
        .fill_ci(fill_ci), .fill_mod(fill_mod),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_wp(rsp_wp),
        .rsp_so(rsp_so), .rsp_ci(rsp_ci), .rsp_mod(rsp_mod),
        .rsp_mod_update(rsp_mod_update)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic capture();
        g_valid = rsp_valid; g_hit = rsp_hit; g_miss = rsp_miss; g_pa = rsp_paddr;
        g_fault = rsp_fault; g_ci = rsp_ci; g_mod = rsp_mod; g_mu = rsp_mod_update;
    endtask

    task automatic do_fill(input logic [31:0] la, input logic [2:0] fc, input logic [31:0] pa,
                           input logic wp, input logic so, input logic ci, input logic md);
        @(negedge clk);
        fill_valid = 1'b1; fill_laddr = la; fill_fc = fc; fill_paddr = pa;
        fill_wp = wp; fill_so = so; fill_ci = ci; fill_mod = md;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_look(input logic [31:0] la, input logic [2:0] fc, input logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = la; lk_fc = fc; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
        capture();
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R1", "hit after reset", {31'd0, rsp_hit}, 32'd0);
        chk("R11", "miss after reset", {31'd0, rsp_miss}, 32'd0);
    endtask

    task automatic t_basic();
        do_fill(32'h1234_5600, 3'd5, 32'hABCD_EF00, 0, 0, 0, 0);
        do_look(32'h1234_56A7, 3'd5, 0);
        chk("R1", "valid one cycle later", {31'd0, g_valid}, 32'd1);
        chk("R2", "hit", {31'd0, g_hit}, 32'd1);
        chk("R2", "paddr", g_pa, 32'hABCD_EFA7);
        chk("R7", "ci clear", {31'd0, g_ci}, 32'd0);
        do_look(32'h1234_57A7, 3'd5, 0);
        chk("R11", "miss flag", {31'd0, g_miss}, 32'd1);
        chk("R11", "miss paddr", g_pa, 32'd0);
    endtask

    task automatic t_fc();
        do_look(32'h1234_56A7, 3'd1, 0);
        chk("R4", "other code misses", {31'd0, g_miss}, 32'd1);
        do_fill(32'h1234_5600, 3'd1, 32'h0000_1100, 0, 0, 0, 0);
        do_look(32'h1234_56A7, 3'd1, 0);
        chk("R4", "user entry paddr", g_pa, 32'h0000_11A7);
        do_look(32'h1234_56A7, 3'd5, 0);
        chk("R4", "super entry paddr", g_pa, 32'hABCD_EFA7);
    endtask

    task automatic t_wp();
        do_fill(32'h2000_0000, 3'd1, 32'h0002_0000, 1, 0, 0, 0);
        do_look(32'h2000_0010, 3'd1, 0);
        chk("R5", "read no fault", {31'd0, g_fault}, 32'd0);
        chk("R5", "read paddr", g_pa, 32'h0002_0010);
        do_look(32'h2000_0010, 3'd1, 1);
        chk("R5", "write fault", {31'd0, g_fault}, 32'd1);
        chk("R5", "write paddr zero", g_pa, 32'd0);
        chk("R5", "no update on fault", {31'd0, g_mu}, 32'd0);
        do_look(32'h2000_0010, 3'd1, 0);
        chk("R10", "fault write left mod clear", {31'd0, g_mod}, 32'd0);
    endtask

    task automatic t_sup();
        do_fill(32'h3000_0000, 3'd1, 32'h0003_0000, 0, 1, 0, 0);
        do_look(32'h3000_0004, 3'd1, 0);
        chk("R6", "user fault", {31'd0, g_fault}, 32'd1);
        do_fill(32'h3000_0000, 3'd5, 32'h0003_0000, 0, 1, 0, 0);
        do_look(32'h3000_0004, 3'd5, 0);
        chk("R6", "super no fault", {31'd0, g_fault}, 32'd0);
        chk("R6", "super paddr", g_pa, 32'h0003_0004);
    endtask

    task automatic t_ci();
        do_fill(32'h3100_0000, 3'd5, 32'h0031_0000, 0, 0, 1, 0);
        do_look(32'h3100_0042, 3'd5, 0);
        chk("R7", "ci set", {31'd0, g_ci}, 32'd1);
        chk("R7", "ci paddr", g_pa, 32'h0031_0042);
    endtask

    task automatic t_mod();
        do_fill(32'h4000_0000, 3'd1, 32'h0004_0000, 0, 0, 0, 0);
        do_look(32'h4000_0001, 3'd1, 0);
        chk("R10", "read no update", {31'd0, g_mu}, 32'd0);
        do_look(32'h4000_0001, 3'd1, 1);
        chk("R10", "first write update", {31'd0, g_mu}, 32'd1);
        chk("R10", "old mod shown", {31'd0, g_mod}, 32'd0);
        do_look(32'h4000_0001, 3'd1, 1);
        chk("R10", "second write no update", {31'd0, g_mu}, 32'd0);
        chk("R10", "mod now set", {31'd0, g_mod}, 32'd1);
        do_fill(32'h4100_0000, 3'd1, 32'h0041_0000, 0, 0, 0, 1);
        do_look(32'h4100_0001, 3'd1, 1);
        chk("R10", "premodified no update", {31'd0, g_mu}, 32'd0);
    endtask

    task automatic t_page();
        do_flush();
        page_sel = 3'd3;
        do_fill(32'h5000_0000, 3'd1, 32'h7000_0000, 0, 0, 0, 0);
        do_look(32'h5000_07FF, 3'd1, 0);
        chk("R3", "2K offset pass", g_pa, 32'h7000_07FF);
        do_look(32'h5000_0800, 3'd1, 0);
        chk("R3", "2K next page misses", {31'd0, g_miss}, 32'd1);
        @(negedge clk); page_sel = 3'd7;
        do_fill(32'h6000_0000, 3'd1, 32'h0800_0000, 0, 0, 0, 0);
        do_look(32'h6000_7FFF, 3'd1, 0);
        chk("R3", "32K offset pass", g_pa, 32'h0800_7FFF);
        do_look(32'h6000_8000, 3'd1, 0);
        chk("R3", "32K next page misses", {31'd0, g_miss}, 32'd1);
        @(negedge clk); page_sel = 3'd0;
        do_flush();
    endtask

    task automatic t_ignore();
        ign_bits = 4'd4;
        do_fill(32'h1800_0100, 3'd1, 32'h0009_0000, 0, 0, 0, 0);
        do_look(32'hF800_0123, 3'd1, 0);
        chk("R8", "upper bits ignored", g_pa, 32'h0009_0023);
        @(negedge clk); ign_bits = 4'd0;
        do_look(32'hF800_0123, 3'd1, 0);
        chk("R8", "upper bits compared again", {31'd0, g_miss}, 32'd1);
        do_look(32'h0800_0123, 3'd1, 0);
        chk("R8", "stored tag zeroed", g_pa, 32'h0009_0023);
        do_flush();
        ign_bits = 4'd15;
        do_fill(32'hFFFE_0200, 3'd1, 32'h0000_0500, 0, 0, 0, 0);
        do_look(32'h0000_0233, 3'd1, 0);
        chk("R8", "15 bits ignored", g_pa, 32'h0000_0533);
        @(negedge clk); ign_bits = 4'd0;
        do_flush();
    endtask

    task automatic t_bypass();
        @(negedge clk); xlat_off = 1'b1;
        do_look(32'hDEAD_BEEF, 3'd1, 1);
        chk("R9", "override hit", {31'd0, g_hit}, 32'd1);
        chk("R9", "override paddr", g_pa, 32'hDEAD_BEEF);
        chk("R9", "override no update", {31'd0, g_mu}, 32'd0);
        @(negedge clk); xlat_off = 1'b0; xlat_enable = 1'b0;
        do_look(32'h0BAD_F00D, 3'd1, 0);
        chk("R9", "disabled paddr", g_pa, 32'h0BAD_F00D);
        chk("R9", "disabled no fault", {31'd0, g_fault}, 32'd0);
        @(negedge clk); xlat_enable = 1'b1;
        do_look(32'hDEAD_BEEF, 3'd1, 0);
        chk("R9", "enabled again misses", {31'd0, g_miss}, 32'd1);
    endtask

    task automatic t_flush();
        do_fill(32'h0A00_0000, 3'd5, 32'h000A_0000, 0, 0, 0, 0);
        do_look(32'h0A00_0001, 3'd5, 0);
        chk("R13", "hit before flush", {31'd0, g_hit}, 32'd1);
        do_flush();
        do_look(32'h0A00_0001, 3'd5, 0);
        chk("R13", "miss after flush", {31'd0, g_miss}, 32'd1);
    endtask

    task automatic t_same();
        @(negedge clk);
        fill_valid = 1'b1; fill_laddr = 32'h0B00_0000; fill_fc = 3'd5;
        fill_paddr = 32'h000B_0000; fill_wp = 0; fill_so = 0; fill_ci = 0; fill_mod = 0;
        lk_valid = 1'b1; lk_addr = 32'h0B00_0001; lk_fc = 3'd5; lk_write = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        capture();
        chk("R1", "same-cycle lookup sees old state", {31'd0, g_miss}, 32'd1);
        do_look(32'h0B00_0001, 3'd5, 0);
        chk("R1", "next lookup sees fill", g_pa, 32'h000B_0001);
    endtask

    task automatic t_overwrite();
        do_fill(32'h0C00_0000, 3'd5, 32'h0001_0000, 0, 0, 0, 0);
        do_fill(32'h0C00_0000, 3'd5, 32'h0002_0000, 0, 0, 0, 0);
        do_look(32'h0C00_0005, 3'd5, 0);
        chk("R14", "overwritten frame", g_pa, 32'h0002_0005);
    endtask

    task automatic t_repl();
        do_flush();
        for (int i = 0; i < 22; i++)
            do_fill(32'h0100_0000 + (i << 8), 3'd5, 32'h0040_0000 + (i << 8), 0, 0, 0, 0);
        for (int i = 0; i < 22; i++) begin
            do_look(32'h0100_0000 + (i << 8) + 32'h11, 3'd5, 0);
            chk("R2", $sformatf("slot %0d held", i), g_pa, 32'h0040_0011 + (i << 8));
        end
        do_fill(32'h0200_0000, 3'd5, 32'h0050_0000, 0, 0, 0, 0);
        do_look(32'h0100_0000, 3'd5, 0);
        chk("R12", "first victim evicted", {31'd0, g_miss}, 32'd1);
        do_look(32'h0100_0100, 3'd5, 0);
        chk("R12", "neighbour kept", {31'd0, g_hit}, 32'd1);
        do_fill(32'h0200_0100, 3'd5, 32'h0050_0100, 0, 0, 0, 0);
        do_look(32'h0100_0200, 3'd5, 0);
        chk("R12", "second victim evicted", {31'd0, g_miss}, 32'd1);
        do_look(32'h0100_0300, 3'd5, 0);
        chk("R12", "unreferenced slot kept", {31'd0, g_hit}, 32'd1);
        do_look(32'h0200_0104, 3'd5, 0);
        chk("R12", "new mapping present", g_pa, 32'h0050_0104);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fc();
        t_wp();
        t_sup();
        t_ci();
        t_mod();
        t_page();
        t_ignore();
        t_bypass();
        t_flush();
        t_same();
        t_overwrite();
        t_repl();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule